// File: doc/BRIEF.md
# Processor Status Register Write Unit

This block keeps a 32-bit processor status word and applies software stores to it. A store does not simply overwrite the word. A per-bit writable mask, fixed at configuration time, decides which bits a store may touch. When the newer-release rule set is enabled, three further restrictions apply on top of the mask. Two flag bits can only be cleared. A store that would put the privilege-mode field into its illegal encoding is dropped for that field. The three extended address-segment enables gate one another in a chain.

When a store withdraws access to any extended segment, the block raises a registered one-cycle request. The translation cache outside the block uses this request to flush itself.

Every store also refreshes a per-thread shadow word. The shadow copies the coprocessor-usable nibble, the DSP-enable bit and the privilege-mode field of the new status value. It also takes the current address-space identifier, masked to the configured identifier width. All other shadow bits are kept as they were. The current status value can be read on a combinational read port.

Top module: `csr_status_wr`

## Requirements
- R1: On a write (`wr_en`=1), each status bit whose `cfg_wmask` bit is 1 takes the `wr_data` bit after the restrictions of R2 to R4. Each bit whose mask bit is 0 keeps its old value.
- R2: With `cfg_r6`=1, when both mask bits of the mode field [4:3] are 1 and `wr_data[4:3]` is 2'b11, the mode field keeps its old value. If only one of the two mask bits is 1, plain R1 applies.
- R3: With `cfg_r6`=1, writing 1 to bit 20 (soft-reset flag) or to bit 19 (NMI flag) leaves that bit unchanged. Writing 0 to either bit clears it, subject to the mask.
- R4: With `cfg_r6`=1 and the wide-segment option on, the written bit 6 is forced to 0 when written bit 7 is 0. The written bit 5 is forced to 0 when the resulting bit 6 is 0.
- R5: `flush_req` is 1 for exactly the cycle after a write in which at least one of bits 7, 6 and 5 went from 1 to 0. Otherwise it is 0.
- R6: On a write, the shadow word takes these values, all from the new status value: [31:28] from status [31:28], [27] from status [24], and [12:11] from status [4:3]. Shadow [9:0] takes `cur_asid & cfg_asid_mask`. All other shadow bits are unchanged.
- R7: During and after reset, the status word reads 32'h0040_0004 (bit 22 boot-vector and bit 2 error-level set). The shadow word reads 0 and `flush_req` reads 0.
- R8: Without a write, the status word and the shadow word do not change. `rd_data` always presents the held status value in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_r6 | input | 1 | Enables the newer-release write restrictions |
| cfg_wmask | input | 32 | Per-bit writable mask |
| cfg_asid_mask | input | 10 | Mask applied to the address-space identifier |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wr_data | input | 32 | Value being written |
| cur_asid | input | 10 | Current address-space identifier |
| rd_data | output | 32 | Current status value |
| shadow_q | output | 32 | Per-thread shadow status word |
| flush_req | output | 1 | One-cycle translation flush request |

## Verification
The bench targets the following corner cases:
- Mode-field stores of 2'b11 with the full mask and with a half mask. A design that tests only one mask bit would drop a legal single-bit store.
- Stores of 1 to the two clear-only flags, both after the flags were set and while they are clear. A wrong design would set them or fail to clear them.
- Each link of the segment chain, including the case where the top bit is 0 but the lower bits are written 1. A broken chain would leave a lower segment enabled.
- Flush requests on a withdrawn segment, with and without mask coverage and with no write. A wrong detector would flush on a rising bit or on idle cycles.
- Long random runs against a behavioural model. These catch shadow field misplacement and identifier masking errors.

// File: rtl/csr_stat_pkg.sv
`timescale 1ns/1ps
package csr_stat_pkg;
   // status word bit positions (behaviour depends on these)
   localparam int POS_CU_HI    = 31;
   localparam int POS_CU_LO    = 28;
   localparam int POS_DSP      = 24;
   localparam int POS_BOOTVEC  = 22;
   localparam int POS_SOFTRST  = 20;
   localparam int POS_NMIF     = 19;
   localparam int POS_XK       = 7;
   localparam int POS_XS       = 6;
   localparam int POS_XU       = 5;
   localparam int POS_MODE_HI  = 4;
   localparam int POS_MODE_LO  = 3;
   localparam int POS_ERRLVL   = 2;
   // shadow word positions
   localparam int SH_CU_LO     = 28;
   localparam int SH_DSP       = 27;
   localparam int SH_MODE_LO   = 11;
   localparam int MODE_W       = POS_MODE_HI - POS_MODE_LO + 1;
   localparam int CU_W         = POS_CU_HI - POS_CU_LO + 1;

   typedef struct packed {
      logic [CU_W-1:0]   cu;
      logic              dsp;
      logic [MODE_W-1:0] mode;
   } shadow_fields_t;
endpackage

// File: rtl/csr_stat_shape.sv
`timescale 1ns/1ps
module csr_stat_shape
   import csr_stat_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter bit HAS_WIDE = 1'b1
) (
   input  logic              r6,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [DATA_W-1:0] wmask,
   output logic [DATA_W-1:0] eff_data,
   output logic [DATA_W-1:0] eff_mask
);
   logic [DATA_W-1:0] chained;

   generate
      if (HAS_WIDE) begin : g_chain
         always_comb begin
            chained = wr_data;
            if (r6) begin
               chained[POS_XS] = wr_data[POS_XS] & wr_data[POS_XK];
               chained[POS_XU] = wr_data[POS_XU] & chained[POS_XS];
            end
         end
      end else begin : g_flat
         assign chained = wr_data;
      end
   endgenerate

   always_comb begin
      eff_mask = wmask;
      if (r6) begin
         if ((&wmask[POS_MODE_HI:POS_MODE_LO]) && (&chained[POS_MODE_HI:POS_MODE_LO]))
            eff_mask[POS_MODE_HI:POS_MODE_LO] = '0;
         eff_mask[POS_SOFTRST] = wmask[POS_SOFTRST] & ~chained[POS_SOFTRST];
         eff_mask[POS_NMIF]    = wmask[POS_NMIF]    & ~chained[POS_NMIF];
      end
   end

   assign eff_data = chained;
endmodule

// File: rtl/csr_stat_reg.sv
`timescale 1ns/1ps
module csr_stat_reg
   import csr_stat_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter bit HAS_WIDE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [DATA_W-1:0] eff_data,
   input  logic [DATA_W-1:0] eff_mask,
   output logic [DATA_W-1:0] q,
   output shadow_fields_t    fields_next,
   output logic              flush
);
   localparam logic [DATA_W-1:0] RST_VAL =
      (DATA_W'(1) << POS_BOOTVEC) | (DATA_W'(1) << POS_ERRLVL);
   localparam logic [DATA_W-1:0] EXT_BITS =
      (DATA_W'(1) << POS_XK) | (DATA_W'(1) << POS_XS) | (DATA_W'(1) << POS_XU);

   logic [DATA_W-1:0] nxt;
   logic              lost;

   assign nxt = (q & ~eff_mask) | (eff_data & eff_mask);

   assign fields_next.cu   = nxt[POS_CU_HI:POS_CU_LO];
   assign fields_next.dsp  = nxt[POS_DSP];
   assign fields_next.mode = nxt[POS_MODE_HI:POS_MODE_LO];

   generate
      if (HAS_WIDE) begin : g_seg
         assign lost = |(q & ~nxt & EXT_BITS);
      end else begin : g_noseg
         assign lost = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q     <= RST_VAL;
         flush <= 1'b0;
      end else begin
         flush <= we & lost;
         if (we) q <= nxt;
      end
   end
endmodule

// File: rtl/csr_stat_shadow.sv
`timescale 1ns/1ps
module csr_stat_shadow
   import csr_stat_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ASID_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  shadow_fields_t    fields,
   input  logic [ASID_W-1:0] asid,
   input  logic [ASID_W-1:0] asid_mask,
   output logic [DATA_W-1:0] q
);
   logic [DATA_W-1:0] nxt;

   always_comb begin
      nxt = q;
      nxt[SH_CU_LO +: CU_W]     = fields.cu;
      nxt[SH_DSP]               = fields.dsp;
      nxt[SH_MODE_LO +: MODE_W] = fields.mode;
      nxt[ASID_W-1:0]           = asid & asid_mask;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= nxt;
   end
endmodule

// File: rtl/csr_status_wr.sv
`timescale 1ns/1ps
module csr_status_wr
   import csr_stat_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int ASID_W   = 10,
   parameter bit HAS_WIDE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_r6,
   input  logic [DATA_W-1:0] cfg_wmask,
   input  logic [ASID_W-1:0] cfg_asid_mask,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ASID_W-1:0] cur_asid,
   output logic [DATA_W-1:0] rd_data,
   output logic [DATA_W-1:0] shadow_q,
   output logic              flush_req
);
   initial begin
      assert (DATA_W >= 32) else $fatal(1, "status word must be at least 32 bits");
      assert (ASID_W >= 1 && ASID_W <= SH_MODE_LO)
         else $fatal(1, "identifier field overlaps shadow mode field");
   end

   logic [DATA_W-1:0] eff_data, eff_mask, status_q;
   shadow_fields_t    fnext;

   csr_stat_shape #(.DATA_W(DATA_W), .HAS_WIDE(HAS_WIDE)) u_shape (
      .r6(cfg_r6), .wr_data(wr_data), .wmask(cfg_wmask),
      .eff_data(eff_data), .eff_mask(eff_mask));

   csr_stat_reg #(.DATA_W(DATA_W), .HAS_WIDE(HAS_WIDE)) u_reg (
      .clk(clk), .rst_n(rst_n), .we(wr_en), .eff_data(eff_data),
      .eff_mask(eff_mask), .q(status_q), .fields_next(fnext), .flush(flush_req));

   csr_stat_shadow #(.DATA_W(DATA_W), .ASID_W(ASID_W)) u_shadow (
      .clk(clk), .rst_n(rst_n), .we(wr_en), .fields(fnext),
      .asid(cur_asid), .asid_mask(cfg_asid_mask), .q(shadow_q));

   assign rd_data = status_q;
endmodule

// File: rtl/csr_status_chk.sv
`timescale 1ns/1ps
module csr_status_chk
   import csr_stat_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter bit HAS_WIDE = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_r6,
   input logic [DATA_W-1:0] cfg_wmask,
   input logic              wr_en,
   input logic [DATA_W-1:0] wr_data,
   input logic [DATA_W-1:0] rd_data,
   input logic [DATA_W-1:0] shadow_q,
   input logic              flush_req
);
   localparam logic [DATA_W-1:0] EXT_BITS =
      (DATA_W'(1) << POS_XK) | (DATA_W'(1) << POS_XS) | (DATA_W'(1) << POS_XU);
   localparam logic [DATA_W-1:0] RST_VAL =
      (DATA_W'(1) << POS_BOOTVEC) | (DATA_W'(1) << POS_ERRLVL);

   AST_RESET_VALUE: assert property (@(posedge clk) !rst_n |=> rd_data == RST_VAL); // R7
   AST_PLAIN_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && !cfg_r6 |=> rd_data == (($past(rd_data) & ~$past(cfg_wmask)) |
                                       ($past(wr_data) & $past(cfg_wmask)))); // R1
   AST_MODE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && cfg_r6 && (&cfg_wmask[POS_MODE_HI:POS_MODE_LO]) &&
      (&wr_data[POS_MODE_HI:POS_MODE_LO]) |=> $stable(rd_data[POS_MODE_HI:POS_MODE_LO])); // R2
   AST_FLAG_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && cfg_r6 |=> !$rose(rd_data[POS_SOFTRST]) && !$rose(rd_data[POS_NMIF])); // R3
   AST_SEG_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
      HAS_WIDE && wr_en && cfg_r6 && !wr_data[POS_XK] && cfg_wmask[POS_XS]
      |=> !rd_data[POS_XS]); // R4
   AST_FLUSH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      flush_req |-> $past(wr_en) && (($past(rd_data) & ~rd_data & EXT_BITS) != '0)); // R5
   AST_SHADOW_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> shadow_q[SH_CU_LO +: CU_W] == rd_data[POS_CU_HI:POS_CU_LO] &&
                shadow_q[SH_DSP] == rd_data[POS_DSP] &&
                shadow_q[SH_MODE_LO +: MODE_W] == rd_data[POS_MODE_HI:POS_MODE_LO]); // R6
   AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(rd_data) && $stable(shadow_q) && !flush_req); // R8
endmodule

bind csr_status_wr csr_status_chk #(.DATA_W(DATA_W), .HAS_WIDE(HAS_WIDE)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_r6(cfg_r6), .cfg_wmask(cfg_wmask),
   .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
   .shadow_q(shadow_q), .flush_req(flush_req));

// File: tb/sim_csr_status_wr.sv
`timescale 1ns/1ps
module sim_csr_status_wr;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_r6 = 1'b0;
   logic [31:0] cfg_wmask = '0;
   logic [9:0]  cfg_asid_mask = '0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [9:0]  cur_asid = '0;
   logic [31:0] rd_data, shadow_q;
   logic        flush_req;

   int nchk = 0, nfail = 0;
   bit done = 0;

   // behavioural reference state
   logic [31:0] m_st, m_sh;
   logic        m_fl;

   always #2.5 clk = ~clk;

   csr_status_wr u0 (.clk(clk), .rst_n(rst_n), .cfg_r6(cfg_r6), .cfg_wmask(cfg_wmask),
      .cfg_asid_mask(cfg_asid_mask), .wr_en(wr_en), .wr_data(wr_data),
      .cur_asid(cur_asid), .rd_data(rd_data), .shadow_q(shadow_q), .flush_req(flush_req));

   task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] ref_store(input logic [31:0] old, input logic [31:0] wd,
                                             input logic [31:0] wm, input logic r6);
      logic [31:0] v = wd, m = wm, r;
      if (r6) begin
         if (v[7] == 1'b0) v[6] = 1'b0;
         if (v[6] == 1'b0) v[5] = 1'b0;
         if (wm[4:3] == 2'b11 && v[4:3] == 2'b11) m[4:3] = 2'b00;
         if (v[20]) m[20] = 1'b0;
         if (v[19]) m[19] = 1'b0;
      end
      for (int i = 0; i < 32; i++) r[i] = m[i] ? v[i] : old[i];
      return r;
   endfunction

   task automatic step(input logic we, input logic [31:0] wd, input logic [31:0] wm,
                       input logic r6, input logic [9:0] asid, input logic [9:0] am,
                       input string tag);
      logic [31:0] n;
      wr_en = we; wr_data = wd; cfg_wmask = wm; cfg_r6 = r6;
      cur_asid = asid; cfg_asid_mask = am;
      @(posedge clk);
      if (we) begin
         n = ref_store(m_st, wd, wm, r6);
         m_fl = (m_st[7] && !n[7]) || (m_st[6] && !n[6]) || (m_st[5] && !n[5]);
         m_st = n;
         m_sh[31:28] = n[31:28];
         m_sh[27]    = n[24];
         m_sh[12:11] = n[4:3];
         m_sh[9:0]   = asid & am;
      end else begin
         m_fl = 1'b0;
      end
      @(negedge clk);
      cmp({tag, " status"}, rd_data, m_st);
      cmp({tag, " shadow"}, shadow_q, m_sh);
      cmp({tag, " flush"}, {31'b0, flush_req}, {31'b0, m_fl});
   endtask

   initial begin
      m_st = 32'h0040_0004; m_sh = '0; m_fl = 1'b0;
      repeat (3) @(negedge clk);
      cmp("R7 reset status", rd_data, 32'h0040_0004);
      cmp("R7 reset shadow", shadow_q, 32'h0);
      cmp("R7 reset flush", {31'b0, flush_req}, 32'h0);
      rst_n = 1'b1;
      step(0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 10'h3FF, 10'h3FF, "R8 idle after reset");
      cmp("R7 held after release", rd_data, 32'h0040_0004);
      // R1 plain masked stores
      step(1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 10'h155, 10'h0FF, "R1 all ones");
      cmp("R1 all ones direct", rd_data, 32'hFFFF_FFFF);
      step(1, 32'h0000_0000, 32'hFFFF_FFFF, 0, 10'h2AA, 10'h3FF, "R5 drop all segs");
      cmp("R5 flush after clear", {31'b0, flush_req}, 32'h1);
      step(0, 32'h0, 32'hFFFF_FFFF, 0, 10'h0, 10'h3FF, "R5 pulse ends");
      step(1, 32'hA5A5_5A5A, 32'h0000_FF00, 0, 10'h011, 10'h00F, "R1 partial mask");
      step(1, 32'h5A5A_A5A5, 32'hF0F0_0000, 0, 10'h3C3, 10'h3FF, "R6 partial mask");
      // R2 mode field
      step(1, 32'h0000_0008, 32'hFFFF_FFFF, 1, 10'h0, 10'h3FF, "R2 mode 01");
      step(1, 32'h0000_0018, 32'hFFFF_FFFF, 1, 10'h0, 10'h3FF, "R2 mode 11 dropped");
      cmp("R2 mode kept", {30'b0, rd_data[4:3]}, 32'h1);
      step(1, 32'h0000_0018, 32'h0000_0010, 1, 10'h0, 10'h3FF, "R2 half mask");
      cmp("R2 half mask bit4", {31'b0, rd_data[4]}, 32'h1);
      // R3 clear-only flags
      step(1, 32'h0018_0000, 32'h0018_0000, 0, 10'h0, 10'h3FF, "R3 set flags legacy");
      step(1, 32'h0018_0000, 32'h0018_0000, 1, 10'h0, 10'h3FF, "R3 write one kept");
      step(1, 32'h0000_0000, 32'h0018_0000, 1, 10'h0, 10'h3FF, "R3 cleared");
      step(1, 32'h0018_0000, 32'h0018_0000, 1, 10'h0, 10'h3FF, "R3 no set");
      cmp("R3 flags stay clear", rd_data & 32'h0018_0000, 32'h0);
      // R4 chain and R5 flush
      step(1, 32'h0000_00E0, 32'h0000_00E0, 1, 10'h0, 10'h3FF, "R4 all on");
      step(1, 32'h0000_0060, 32'h0000_00E0, 1, 10'h0, 10'h3FF, "R4 top off");
      cmp("R4 chain cleared", rd_data & 32'hE0, 32'h0);
      cmp("R5 flush on top off", {31'b0, flush_req}, 32'h1);
      step(1, 32'h0000_00E0, 32'h0000_00E0, 1, 10'h0, 10'h3FF, "R5 rise no flush");
      step(1, 32'h0000_00A0, 32'h0000_00E0, 1, 10'h0, 10'h3FF, "R4 middle off");
      step(1, 32'h0000_00E0, 32'h0000_00E0, 1, 10'h0, 10'h3FF, "R4 back on");
      step(1, 32'h0000_0000, 32'hFFFF_FF1F, 1, 10'h0, 10'h3FF, "R5 unmasked no flush");
      step(0, 32'h0000_0000, 32'hFFFF_FFFF, 1, 10'h1, 10'h3FF, "R8 idle no flush");
      // R6 identifier masking
      step(1, 32'hF100_0018, 32'hFFFF_FFFF, 0, 10'h3FF, 10'h0FF, "R6 asid 8 bit");
      step(1, 32'h0000_0000, 32'hF000_0000, 0, 10'h2F0, 10'h3FF, "R6 asid 10 bit");
      for (int k = 0; k < 400; k++) begin
         logic [31:0] wm;
         wm = ($urandom_range(0, 3) == 0) ? 32'hFFFF_FFFF : $urandom();
         step(($urandom_range(0, 3) != 0), $urandom(), wm, $urandom_range(0, 1) == 1,
              10'($urandom()), 10'($urandom()), "R1 random");
      end
      done = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

   initial begin
      #(100_000);
      if (!done) begin
         nchk++; nfail++;
         $display("FAIL watchdog R8 act=%h exp=%h", 0, 1);
         $display("%0d/%0d checks passed", nchk - nfail, nchk);
         $finish;
      end
   end
endmodule